// File: doc/BRIEF.md
# Two-Wire Start Detector and Clock Stretcher

This block sits beside a shift-and-count engine on an open-drain two-wire bus. It watches the clock and data lines. A start condition is a falling data edge while the clock is high. When it sees one, it raises a start flag and, if enabled, an interrupt request. A stop condition is a rising data edge while the clock is high, and it raises a separate stop flag. Software clears each flag with a one-cycle clear strobe.

Start capture does not need the system clock. An edge-triggered capture cell, clocked by the data line itself, holds the event and drives a wake request at once. The event is then carried into the system clock domain, where it sets the flag and re-arms the cell.

The block can also insert wait states by pulling the bus clock low. Depending on the mode, this happens after a start, or after a start and after each transfer-counter overflow. The pull-down engages only once the clock has been seen low, so it never cuts a high clock phase short. It is held until software clears the matching condition. The block never drives a line high: it only enables a pull-down, and an external pull-up gives the high level. The bus clock must stay at or below one sixteenth of the system clock.

Top module: `tws_ctrl`

## Requirements
- R1: A falling `sda_in` while `scl_in` is high sets `start_flag` within 6 clock cycles when `mode` is not 0. A falling `sda_in` while `scl_in` is low sets nothing.
- R2: `irq` is high exactly when `start_flag` is high and `start_ie` is 1.
- R3: With `mode` not 0, `wake` rises at the start condition with no system clock edge needed. It falls again within 6 cycles of the clock running.
- R4: A rising `sda_in` while `scl_in` is high sets `stop_flag` when `mode` is not 0. A `clr_stop` strobe clears it.
- R5: In `mode` 2 (hold after start) and `mode` 3 (hold after start and overflow), a start arms a hold. `scl_pull` asserts only after `scl_in` has been seen low, and it stays asserted until a `clr_start` strobe, even when the master releases the clock.
- R6: In `mode` 1 (detect only) a start never asserts `scl_pull`.
- R7: In `mode` 3 an `ovf_stb` pulse arms a hold that pulls the low clock down until a `clr_ovf` strobe. In `mode` 0, 1 and 2, `ovf_stb` has no effect on `scl_pull`.
- R8: In `mode` 0 (off) no flag is set, `wake` stays low and `scl_pull` is low from the cycle after `mode` becomes 0.
- R9: A `clr_start` strobe clears `start_flag` and `irq` and releases a hold armed by a start. The clock line then reads high again through the pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 off, 1 detect only, 2 hold after start, 3 hold after start and overflow |
| start_ie | input | 1 | Interrupt enable for the start flag |
| scl_in | input | 1 | Level read back from the bus clock line |
| sda_in | input | 1 | Level read back from the bus data line |
| ovf_stb | input | 1 | One-cycle strobe on transfer-counter overflow |
| clr_start | input | 1 | One-cycle strobe that clears the start flag |
| clr_stop | input | 1 | One-cycle strobe that clears the stop flag |
| clr_ovf | input | 1 | One-cycle strobe that clears the overflow condition |
| scl_pull | output | 1 | Enables the open-drain pull-down on the bus clock |
| start_flag | output | 1 | Start condition seen |
| stop_flag | output | 1 | Stop condition seen |
| irq | output | 1 | Start interrupt request |
| wake | output | 1 | Asynchronous wake request from the capture cell |

## Verification
The assertions check on every cycle that:
- a synchronised start or stop event sets its flag on the next edge;
- the capture cell produces single-cycle start events;
- the pull-down engages only after a low clock has been sampled;
- a clear with no competing event releases the clock within two edges;
- the off mode drops the pull-down.

Only the bench scenarios can show the behaviour seen at the bus. This covers:
- the asynchronous wake while the system clock is stopped;
- the rejection of a data edge while the clock is low;
- the stretched clock seen as a low line while the master releases it;
- the sweep over all four modes and both interrupt enables.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [1:0] {
        TW_OFF        = 2'd0,
        TW_DETECT     = 2'd1,
        TW_HOLD_START = 2'd2,
        TW_HOLD_ALL   = 2'd3
    } tw_mode_e;

    typedef struct packed {
        logic start;
        logic stop;
    } tw_evt_t;

    localparam int unsigned TW_SYNC_STAGES = 2;

    function automatic logic mode_active(tw_mode_e m);
        return m != TW_OFF;
    endfunction

    function automatic logic hold_after_start(tw_mode_e m);
        return (m == TW_HOLD_START) || (m == TW_HOLD_ALL);
    endfunction

    function automatic logic hold_after_ovf(tw_mode_e m);
        return m == TW_HOLD_ALL;
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tws_start_catch.sv
module tws_start_catch #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic sda_in,
    input  logic scl_in,
    output logic wake,
    output logic start_evt
);
    logic catch_clr;
    logic cap;
    logic cap_s;
    logic cap_s_d;

    // Re-arm: clear the cell once the capture reached the clock domain,
    // and keep it cleared while the block is off or in reset.
    always_ff @(posedge clk) begin
        if (rst) catch_clr <= 1'b1;
        else     catch_clr <= !active || cap_s;
    end

    // Capture cell clocked by the data line: runs with the system clock stopped.
    always_ff @(negedge sda_in or posedge catch_clr) begin
        if (catch_clr)   cap <= 1'b0;
        else if (scl_in) cap <= 1'b1;
    end

    tws_line_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_cap_sync (
        .clk (clk),
        .rst (rst),
        .d   (cap),
        .q   (cap_s)
    );

    always_ff @(posedge clk) begin
        if (rst) cap_s_d <= 1'b0;
        else     cap_s_d <= cap_s;
    end

    assign start_evt = cap_s && !cap_s_d;
    assign wake      = cap;

    // R1: each captured start yields exactly one event cycle
    a_r1_single_event: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !start_evt);
endmodule

// File: rtl/tws_stretch.sv
module tws_stretch
    import tws_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tw_mode_e mode,
    input  logic     scl_s,
    input  logic     start_evt,
    input  logic     ovf_stb,
    input  logic     clr_start,
    input  logic     clr_ovf,
    output logic     scl_pull
);
    logic hold_start;
    logic hold_ovf;
    logic pull_q;

    always_ff @(posedge clk) begin
        if (rst || !mode_active(mode))                 hold_start <= 1'b0;
        else if (start_evt && hold_after_start(mode))  hold_start <= 1'b1;
        else if (clr_start)                            hold_start <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || !mode_active(mode))                 hold_ovf <= 1'b0;
        else if (ovf_stb && hold_after_ovf(mode))      hold_ovf <= 1'b1;
        else if (clr_ovf)                              hold_ovf <= 1'b0;
    end

    // Engage only from a sampled low clock; once pulled, stay until released.
    always_ff @(posedge clk) begin
        if (rst) pull_q <= 1'b0;
        else     pull_q <= mode_active(mode) && (hold_start || hold_ovf)
                           && (pull_q || !scl_s);
    end

    assign scl_pull = pull_q;

    // R5: the pull-down never cuts into a high clock phase
    a_r5_engage_low: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull) |-> $past(!scl_s));

    // R9: a clear with no competing hold source releases the line
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (clr_start && !hold_ovf && !ovf_stb && !start_evt) |=> ##1 !scl_pull);

    // R8: off mode drops the pull-down on the next edge
    a_r8_off_no_pull: assert property (@(posedge clk) disable iff (rst)
        (mode == TW_OFF) |=> !scl_pull);
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = TW_SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       start_ie,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       ovf_stb,
    input  logic       clr_start,
    input  logic       clr_stop,
    input  logic       clr_ovf,
    output logic       scl_pull,
    output logic       start_flag,
    output logic       stop_flag,
    output logic       irq,
    output logic       wake
);
    tw_mode_e   mode_e;
    logic       active;
    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       sda_d;
    tw_evt_t    evt;

    assign mode_e = tw_mode_e'(mode);
    assign active = mode_active(mode_e);

    tws_line_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    always_ff @(posedge clk) begin
        if (rst) sda_d <= 1'b1;
        else     sda_d <= sda_s;
    end

    tws_start_catch #(.STAGES(SYNC_STAGES)) u_catch (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .wake      (wake),
        .start_evt (evt.start)
    );

    assign evt.stop = sda_s && !sda_d && scl_s;

    // Flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)                        start_flag <= 1'b0;
        else if (evt.start && active)   start_flag <= 1'b1;
        else if (clr_start)             start_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                        stop_flag <= 1'b0;
        else if (evt.stop && active)    stop_flag <= 1'b1;
        else if (clr_stop)              stop_flag <= 1'b0;
    end

    assign irq = start_flag && start_ie;

    tws_stretch u_stretch (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .scl_s     (scl_s),
        .start_evt (evt.start),
        .ovf_stb   (ovf_stb),
        .clr_start (clr_start),
        .clr_ovf   (clr_ovf),
        .scl_pull  (scl_pull)
    );

    // R1: a synchronised start sets the flag on the next edge
    a_r1_start_sets: assert property (@(posedge clk) disable iff (rst)
        (evt.start && active) |=> start_flag);

    // R4: a synchronised stop sets its flag on the next edge
    a_r4_stop_sets: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && active) |=> stop_flag);

    // R2: the request only follows an enabled, pending flag
    a_r2_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (start_flag && start_ie));
endmodule

// File: tb/sim_tws_ctrl.sv
module sim_tws_ctrl;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst;
    logic [1:0] mode;
    logic       start_ie;
    logic       scl_m, sda_m;
    logic       ovf_stb, clr_start, clr_stop, clr_ovf;
    logic       scl_pull, start_flag, stop_flag, irq, wake;
    logic       scl_line, sda_line;
    int         checks = 0;
    int         fails  = 0;
    logic       done   = 1'b0;

    // Open-drain bus: pull-up gives high unless someone pulls down.
    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m;

    tws_ctrl u0 (
        .clk(clk), .rst(rst), .mode(mode), .start_ie(start_ie),
        .scl_in(scl_line), .sda_in(sda_line), .ovf_stb(ovf_stb),
        .clr_start(clr_start), .clr_stop(clr_stop), .clr_ovf(clr_ovf),
        .scl_pull(scl_pull), .start_flag(start_flag), .stop_flag(stop_flag),
        .irq(irq), .wake(wake)
    );

    initial forever begin
        #2.5;
        if (clk_run) clk = ~clk;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode = 2'd0; start_ie = 1'b0;
        scl_m = 1'b1; sda_m = 1'b1;
        ovf_stb = 1'b0; clr_start = 1'b0; clr_stop = 1'b0; clr_ovf = 1'b0;
        step(4);
        rst = 1'b0;
        step(2);
        chk("R8", "reset start_flag", start_flag, 1'b0);
        chk("R8", "reset stop_flag", stop_flag, 1'b0);
        chk("R8", "reset scl_pull", scl_pull, 1'b0);
        chk("R2", "reset irq", irq, 1'b0);

        // Sweep every mode and both interrupt enables.
        for (int m = 0; m < 4; m++) begin
            for (int ie = 0; ie < 2; ie++) begin
                logic  e_flag, e_hold, e_ovf;
                string r_on, r_hold;
                e_flag = (m != 0);
                e_hold = (m >= 2);
                e_ovf  = (m == 3);
                r_on   = (m == 0) ? "R8" : "R1";
                r_hold = (m == 0) ? "R8" : ((m == 1) ? "R6" : "R5");
                mode = m[1:0]; start_ie = ie[0];
                step(4);
                sda_m = 1'b0;                      // start: data falls, clock high
                step(6);
                chk(r_on, "start_flag after start", start_flag, e_flag);
                chk("R2", "irq after start", irq, e_flag & ie[0]);
                chk("R3", "wake released", wake, 1'b0);
                scl_m = 1'b0;
                step(6);
                chk(r_hold, "scl_pull while clock low", scl_pull, e_hold);
                scl_m = 1'b1;                      // master releases the clock
                step(4);
                chk(r_hold, "scl_pull after master release", scl_pull, e_hold);
                chk(r_hold, "clock line level", scl_line, ~e_hold);
                clr_start = 1'b1; step(1); clr_start = 1'b0;
                step(4);
                chk("R9", "start_flag after clear", start_flag, 1'b0);
                chk("R9", "irq after clear", irq, 1'b0);
                chk("R9", "scl_pull after clear", scl_pull, 1'b0);
                chk("R9", "clock line high", scl_line, 1'b1);
                sda_m = 1'b1;                      // stop: data rises, clock high
                step(6);
                chk((m == 0) ? "R8" : "R4", "stop_flag", stop_flag, e_flag);
                clr_stop = 1'b1; step(1); clr_stop = 1'b0;
                step(3);
                chk("R4", "stop_flag cleared", stop_flag, 1'b0);
                scl_m = 1'b0;
                step(3);
                ovf_stb = 1'b1; step(1); ovf_stb = 1'b0;
                step(5);
                chk("R7", "scl_pull after overflow", scl_pull, e_ovf);
                clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
                step(4);
                chk("R7", "scl_pull after overflow clear", scl_pull, 1'b0);
                scl_m = 1'b1;
                step(3);
            end
        end

        // R1: data falling while the clock is low is not a start.
        mode = 2'd1; start_ie = 1'b1;
        step(4);
        scl_m = 1'b0; step(3);
        sda_m = 1'b0; step(3);
        scl_m = 1'b1; step(6);
        chk("R1", "no start on low-clock data edge", start_flag, 1'b0);
        chk("R2", "no irq on low-clock data edge", irq, 1'b0);
        scl_m = 1'b0; step(3);
        sda_m = 1'b1; step(3);
        scl_m = 1'b1; step(4);

        // R3: start captured with the system clock stopped.
        clk_run = 1'b0;
        #20;
        sda_m = 1'b0;
        #5;
        chk("R3", "wake with clock stopped", wake, 1'b1);
        chk("R3", "flag waits for clock", start_flag, 1'b0);
        clk_run = 1'b1;
        step(6);
        chk("R3", "start_flag after clock resumes", start_flag, 1'b1);
        chk("R3", "wake cleared after sync", wake, 1'b0);
        clr_start = 1'b1; step(1); clr_start = 1'b0;
        scl_m = 1'b0; step(2); sda_m = 1'b1; step(2); scl_m = 1'b1; step(3);

        // R8: off mode ignores a start even with the clock stopped.
        mode = 2'd0;
        step(3);
        clk_run = 1'b0;
        #20;
        sda_m = 1'b0;
        #5;
        chk("R8", "no wake in off mode", wake, 1'b0);
        clk_run = 1'b1;
        step(6);
        chk("R8", "no start_flag in off mode", start_flag, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule